// File: doc/BRIEF.md
# Legacy Integer Arithmetic Extension Unit

This block runs a small set of legacy 32-bit integer operations on two signed operands A and B and a mask operand M. The operations are saturating absolute value, negative absolute value, difference-or-zero, mask insert, and a full unsigned multiply. The multiply's 64-bit product is split across two places: the low word goes to the result and the high word goes to a private extension register called MQ. The extension register is visible on a port.

Operations enter through a valid/ready input stream. The result leaves through a valid/ready output stream that has a single register stage. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the output stream right after that edge. The result stays there, unchanged, until the edge where `out_valid` and `out_ready` are both high.

`in_ready` is high whenever the output stage is empty or is being drained in the same cycle. Back-pressure therefore reaches the input combinationally, and no operation is lost or duplicated.

The overflow flag is a register. It is changed only by the operations that record overflow, and every result carries the flag's updated value.

Top module: `legacy_alu`

## Requirements
- R1: With opcode 0 (absolute value), input A = 0x80000000 gives result 0x7FFFFFFF. Any other negative A gives its two's complement negation, and a non-negative A passes unchanged. The overflow flag becomes 1 exactly when the result was saturated.
- R2: With opcode 1 (negative absolute value), a strictly positive A is negated, and zero or negative A passes unchanged. This opcode leaves the overflow flag unchanged.
- R3: Opcode 2 computes the same result as opcode 1 and always clears the overflow flag to 0.
- R4: With opcode 3 (difference-or-zero), the result is B minus A when B is greater than A under signed comparison, and zero otherwise. The overflow flag becomes 1 exactly when B > A and the difference has bit 31 set; otherwise it becomes 0.
- R5: With opcode 4 (mask insert), the result is (A AND NOT M) OR (B AND M). The overflow flag is unchanged.
- R6: With opcode 5 (multiply), A and B are treated as unsigned. The low 32 bits of the 64-bit product go to the result and the high 32 bits are written to MQ. The overflow flag is unchanged.
- R7: MQ is written only by opcode 5. Every other opcode, and every cycle without an accepted operation, leaves MQ unchanged.
- R8: Opcodes 6 and 7 are reserved. They return a result of zero and change neither MQ nor the overflow flag.
- R9: An operation accepted at a clock edge shows `out_valid` high, with its result and flag, right after that same edge. This is one register stage.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low. `out_result`, `out_ovf` and `mq_value` then hold their values.
- R11: After reset, `out_valid` is 0, `out_ovf` is 0, `mq_value` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 3 | Opcode (0..5 defined, 6..7 reserved) |
| in_a | input | 32 | Operand A |
| in_b | input | 32 | Operand B |
| in_m | input | 32 | Mask operand for mask insert |
| out_valid | output | 1 | Result held in the output stage |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Result word |
| out_ovf | output | 1 | Overflow flag after this operation |
| mq_value | output | 32 | Extension register contents |

## Verification
Every result, its overflow flag and the MQ update are due in the first cycle after the edge that accepts the operation. The bench drives inputs on the falling edge and checks all three outputs on the following falling edge, half a cycle after the accepting edge. In the back-pressure sequence, the bench stalls the consumer for several cycles. On each of those cycles it checks that `in_ready` stays low and that the held result and MQ do not move, even though a second operation is waiting. The second operation's result is then checked one cycle after the release edge.

// File: rtl/legacy_alu_pkg.sv
`timescale 1ns/1ps
package legacy_alu_pkg;
  localparam int OP_W = 3;
  localparam logic [OP_W-1:0] OP_ABS      = 3'd0;
  localparam logic [OP_W-1:0] OP_NABS     = 3'd1;
  localparam logic [OP_W-1:0] OP_NABS_CLR = 3'd2;
  localparam logic [OP_W-1:0] OP_DOZ      = 3'd3;
  localparam logic [OP_W-1:0] OP_MASKINS  = 3'd4;
  localparam logic [OP_W-1:0] OP_MULSPLIT = 3'd5;

  typedef enum logic [1:0] {
    FLAG_KEEP  = 2'd0,
    FLAG_LOAD  = 2'd1,
    FLAG_CLEAR = 2'd2
  } flag_act_e;
endpackage

// File: rtl/lx_sign_unit.sv
`timescale 1ns/1ps
module lx_sign_unit #(
  parameter int W   = 32,
  parameter bit NEG = 1'b0
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] res,
  output logic         sat
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] negated;
  assign negated = ~a + {{(W-1){1'b0}}, 1'b1};

  generate
    if (NEG) begin : g_nabs
      always_comb begin
        sat = 1'b0;
        if (!a[W-1] && (a != '0)) res = negated;
        else                      res = a;
      end
    end else begin : g_abs
      always_comb begin
        sat = 1'b0;
        if (a == MOST_NEG) begin
          res = MOST_POS;
          sat = 1'b1;
        end else if (a[W-1]) begin
          res = negated;
        end else begin
          res = a;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/lx_doz.sv
`timescale 1ns/1ps
module lx_doz #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         ovf
);
  logic         b_above;
  logic [W-1:0] diff;

  assign b_above = $signed(b) > $signed(a);
  assign diff    = b - a;
  assign res     = b_above ? diff : '0;
  assign ovf     = b_above & diff[W-1];
endmodule

// File: rtl/lx_mul_split.sv
`timescale 1ns/1ps
module lx_mul_split #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int PW = 2 * W;
  logic [PW-1:0] prod;

  assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign hi   = prod[PW-1:W];
  assign lo   = prod[W-1:0];
endmodule

// File: rtl/legacy_alu.sv
`timescale 1ns/1ps
module legacy_alu
  import legacy_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic [W-1:0]    in_m,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic            out_ovf,
  output logic [W-1:0]    mq_value
);
  localparam int NSIGN = 2;

  logic [W-1:0] sign_res [NSIGN];
  logic         sign_sat [NSIGN];

  genvar gi;
  generate
    for (gi = 0; gi < NSIGN; gi++) begin : g_sign
      lx_sign_unit #(.W(W), .NEG(gi == 1)) u_sign (
        .a   (in_a),
        .res (sign_res[gi]),
        .sat (sign_sat[gi])
      );
    end
  endgenerate

  logic [W-1:0] doz_res;
  logic         doz_ovf;
  lx_doz #(.W(W)) u_doz (
    .a   (in_a),
    .b   (in_b),
    .res (doz_res),
    .ovf (doz_ovf)
  );

  logic [W-1:0] mul_hi, mul_lo;
  lx_mul_split #(.W(W)) u_mul (
    .a  (in_a),
    .b  (in_b),
    .hi (mul_hi),
    .lo (mul_lo)
  );

  logic [W-1:0] nxt_result;
  logic         nxt_flag;
  flag_act_e    flag_act;
  logic         mq_load;

  always_comb begin
    nxt_result = '0;
    nxt_flag   = 1'b0;
    flag_act   = FLAG_KEEP;
    mq_load    = 1'b0;
    case (in_op)
      OP_ABS: begin
        nxt_result = sign_res[0];
        nxt_flag   = sign_sat[0];
        flag_act   = FLAG_LOAD;
      end
      OP_NABS:     nxt_result = sign_res[1];
      OP_NABS_CLR: begin
        nxt_result = sign_res[1];
        flag_act   = FLAG_CLEAR;
      end
      OP_DOZ: begin
        nxt_result = doz_res;
        nxt_flag   = doz_ovf;
        flag_act   = FLAG_LOAD;
      end
      OP_MASKINS:  nxt_result = (in_a & ~in_m) | (in_b & in_m);
      OP_MULSPLIT: begin
        nxt_result = mul_lo;
        mq_load    = 1'b1;
      end
      default:     nxt_result = '0;
    endcase
  end

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ovf    <= 1'b0;
      mq_value   <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= nxt_result;
      if (mq_load) mq_value <= mul_hi;
      case (flag_act)
        FLAG_LOAD:  out_ovf <= nxt_flag;
        FLAG_CLEAR: out_ovf <= 1'b0;
        default:    out_ovf <= out_ovf;
      endcase
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/legacy_alu_checker.sv
`timescale 1ns/1ps
module legacy_alu_checker
  import legacy_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OP_W-1:0] in_op,
  input logic [W-1:0]    in_a,
  input logic [W-1:0]    in_b,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_result,
  input logic            out_ovf,
  input logic [W-1:0]    mq_value
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_ABS_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_ABS |=> !out_result[W-1]); // R1
  AST_NABS_KEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_NABS |=> $stable(out_ovf)); // R2
  AST_NABS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_NABS_CLR |=> !out_ovf); // R3
  AST_DOZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_DOZ && !($signed(in_b) > $signed(in_a)) |=> out_result == '0 && !out_ovf); // R4
  AST_MQ_ONLY_MUL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && in_op == OP_MULSPLIT) |=> $stable(mq_value)); // R7
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op[2:1] == 2'b11 |=> out_result == '0 && $stable(out_ovf)); // R8
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_ovf)); // R10
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R11
endmodule

bind legacy_alu legacy_alu_checker #(.W(W)) u_chk (.*);

// File: tb/legacy_alu_test.sv
`timescale 1ns/1ps
module legacy_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_a = '0, in_b = '0, in_m = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_ovf;
  logic [31:0] mq_value;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_mq = '0;
  logic        exp_ov = 1'b0;

  always #2 clk = ~clk;

  legacy_alu uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R8";
    endcase
  endfunction

  // reference model: returns result and updates expected MQ and flag
  task automatic model(input logic [2:0] op, input logic [31:0] a, b, m,
                       output logic [31:0] r);
    logic [63:0] p;
    r = '0;
    case (op)
      3'd0: begin
        if (a == 32'h8000_0000) begin r = 32'h7FFF_FFFF; exp_ov = 1'b1; end
        else begin r = a[31] ? (0 - a) : a; exp_ov = 1'b0; end
      end
      3'd1, 3'd2: begin
        r = ($signed(a) > 0) ? (0 - a) : a;
        if (op == 3'd2) exp_ov = 1'b0;
      end
      3'd3: begin
        if ($signed(b) > $signed(a)) begin r = b - a; exp_ov = r[31]; end
        else begin r = '0; exp_ov = 1'b0; end
      end
      3'd4: r = (a & ~m) | (b & m);
      3'd5: begin
        p = {32'd0, a} * {32'd0, b};
        r = p[31:0];
        exp_mq = p[63:32];
      end
      default: r = '0;
    endcase
  endtask

  task automatic run_op(logic [2:0] op, logic [31:0] a, b, m);
    logic [31:0] r;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_m = m;
    model(op, a, b, m, r);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", {31'd0, out_valid}, 32'd1);
    chk(req_of(op), out_result, r);
    chk(op == 3'd5 ? "R6" : "R7", mq_value, exp_mq);
    chk(req_of(op), {31'd0, out_ovf}, {31'd0, exp_ov});
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] corner [6];
    logic [31:0] r1, r2;
    void'($urandom(32'd1234));
    corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'h7FFF_FFFF; corner[5] = 32'h8000_0001;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11", {31'd0, out_valid}, 32'd0);
    chk("R11", {31'd0, out_ovf}, 32'd0);
    chk("R11", mq_value, 32'd0);
    chk("R11", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // directed corners
    run_op(3'd0, 32'h8000_0000, 0, 0);            // R1 saturate, flag set
    run_op(3'd1, 32'h0000_0005, 0, 0);            // R2 flag kept at 1
    run_op(3'd2, 32'hFFFF_FFF0, 0, 0);            // R3 clears flag
    run_op(3'd0, 32'hFFFF_FFFB, 0, 0);            // R1 plain negate
    run_op(3'd1, 32'h0, 0, 0);                    // R2 zero passes
    run_op(3'd3, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0);// R4 overflow
    run_op(3'd3, 32'd10, 32'd3, 0);               // R4 zero
    run_op(3'd3, 32'd3, 32'd10, 0);               // R4 diff
    run_op(3'd4, 32'hAAAA_AAAA, 32'h5555_5555, 32'h00FF_F00F); // R5
    run_op(3'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);// R6 high word to MQ
    run_op(3'd4, 32'h1, 32'h2, 32'h3);            // R7 MQ unchanged
    run_op(3'd6, 32'h1234, 32'h5678, 0);          // R8 reserved
    run_op(3'd7, 32'h8000_0000, 0, 0);            // R8 reserved

    // R10 back-pressure: multiply held while a second operation waits
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 3'd5; in_a = 32'h0001_0003; in_b = 32'h0002_0005; in_m = 0;
    model(3'd5, in_a, in_b, in_m, r1);
    @(negedge clk);
    in_op = 3'd0; in_a = 32'h8000_0000;
    for (int k = 0; k < 3; k++) begin
      chk("R10", {31'd0, in_ready}, 32'd0);
      chk("R10", out_result, r1);
      chk("R10", mq_value, exp_mq);
      @(negedge clk);
    end
    model(3'd0, in_a, in_b, in_m, r2);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", out_result, r2);
    chk("R7", mq_value, exp_mq);
    chk("R1", {31'd0, out_ovf}, 32'd1);

    // constrained random mixed with corners
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [31:0] a, b, m;
      op = 3'($urandom % 8);
      a  = ($urandom % 4 == 0) ? corner[$urandom % 6] : $urandom;
      b  = ($urandom % 4 == 0) ? corner[$urandom % 6] : $urandom;
      m  = $urandom;
      run_op(op, a, b, m);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule